// File: doc/BRIEF.md
# Dual-Pipe Forwarding Integer Register File

This block holds the general-purpose integer state shared by two parallel execution pipes. It stores 32 registers of 64 bits each, used both for scalar integer arithmetic and for address arithmetic. Each pipe has two read ports and one write port, so the block serves four reads and two writes in every cycle.

Reads are combinational from their address inputs. A read whose address matches a write that is active in the same cycle returns that write's data instead of the stored word. This forwarding works inside a pipe and across the pipes, so a result can be consumed in the cycle it is produced. Register index 0 is a constant zero. Reads of it return zero and writes to it are discarded. When both write ports name the same register, the pipe-1 port is treated as the younger instruction. It wins both the forwarding choice and the stored result.

Read ports 0 and 1 belong to pipe 0, and read ports 2 and 3 belong to pipe 1. Write port 0 belongs to pipe 0, and write port 1 belongs to pipe 1.

Top module: `dual_rf`

## Requirements
- R1: A synchronous active-high reset clears every register, so after reset each nonzero index reads 0 when no write to it is active.
- R2: A read of index 0 returns 0 in every cycle, even when a write port is active on index 0 in that cycle.
- R3: A write to index 0 has no effect: index 0 still reads 0 in the following cycles.
- R4: A write with its enable high commits on the rising clock edge, and a later read of that index with no active write to it returns the written data.
- R5: A write port whose enable is low changes no register, whatever its address and data.
- R6: A read port whose nonzero address matches the active write port of its own pipe returns that write data in the same cycle.
- R7: A read port whose nonzero address matches the active write port of the other pipe returns that write data in the same cycle.
- R8: When both write ports are active on the same nonzero index as a read port, the read returns the pipe-1 write data.
- R9: When both write ports are active on the same nonzero index, the register holds the pipe-1 data after the edge.
- R10: A read port with a nonzero address that no active write matches returns the stored word. The four read ports work independently of one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all registers |
| rd_addr | input | 4x5 | Read indices; element 0-1 belong to pipe 0, element 2-3 to pipe 1 |
| rd_data | output | 4x64 | Read results, combinational from rd_addr and the write ports |
| wr_en | input | 2 | Write enables; element 0 for pipe 0, element 1 for pipe 1 |
| wr_addr | input | 2x5 | Write indices, one per pipe |
| wr_data | input | 2x64 | Write data, one per pipe |

## Verification
The assertions take for granted that every write-port input is a known value at each rising edge. They also assume that the cycle before any commit check was out of reset, since a commit only counts when it lands outside reset. The checker relates each read result to the same-cycle write ports and to the writes of the previous cycle. A previous-cycle write is checked only when no current write claims the same index. The stimulus drives every input away from the clock edge and holds it stable through the edge. It draws most addresses from a small window of indices so that writer-reader and writer-writer collisions, index 0 included, occur often.

// File: rtl/dual_rf_pkg.sv
package dual_rf_pkg;

    // Default geometry of the register file.
    localparam int unsigned RF_ENTRIES       = 32;
    localparam int unsigned RF_XLEN          = 64;
    localparam int unsigned RF_PIPES         = 2;
    localparam int unsigned RF_READS_PER_PIPE = 2;

    // Index that is hard-wired to zero.
    localparam int unsigned RF_ZERO_INDEX = 0;

    // Read port to owning pipe.
    function automatic int unsigned port_pipe(input int unsigned port,
                                              input int unsigned reads_per_pipe);
        return port / reads_per_pipe;
    endfunction

endpackage

// File: rtl/rf_storage.sv
module rf_storage
    import dual_rf_pkg::*;
#(
    parameter int unsigned ENTRIES = RF_ENTRIES,
    parameter int unsigned XLEN    = RF_XLEN,
    parameter int unsigned PIPES   = RF_PIPES,
    localparam int unsigned AW     = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [PIPES-1:0]            wr_en,
    input  logic [PIPES-1:0][AW-1:0]    wr_addr,
    input  logic [PIPES-1:0][XLEN-1:0]  wr_data,
    output logic [ENTRIES-1:0][XLEN-1:0] regs_q
);

    for (genvar r = 0; r < ENTRIES; r++) begin : g_entry
        if (r == RF_ZERO_INDEX) begin : g_zero
            // Constant entry: no flops, writes never land here.
            assign regs_q[r] = '0;
        end else begin : g_reg
            logic [XLEN-1:0] q;
            logic [XLEN-1:0] nxt;

            // Ascending scan: the highest-numbered (youngest) pipe wins.
            always_comb begin
                nxt = q;
                for (int p = 0; p < PIPES; p++) begin
                    if (wr_en[p] && (wr_addr[p] == AW'(r))) begin
                        nxt = wr_data[p];
                    end
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q <= nxt;
                end
            end

            assign regs_q[r] = q;
        end
    end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import dual_rf_pkg::*;
#(
    parameter int unsigned ENTRIES = RF_ENTRIES,
    parameter int unsigned XLEN    = RF_XLEN,
    parameter int unsigned PIPES   = RF_PIPES,
    localparam int unsigned AW     = $clog2(ENTRIES)
) (
    input  logic [AW-1:0]               rd_addr,
    input  logic [ENTRIES-1:0][XLEN-1:0] regs_q,
    input  logic [PIPES-1:0]            wr_en,
    input  logic [PIPES-1:0][AW-1:0]    wr_addr,
    input  logic [PIPES-1:0][XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]             rd_data
);

    logic [XLEN-1:0] stored;
    logic [XLEN-1:0] fwd;

    assign stored = regs_q[rd_addr];

    // Forwarding: a later pipe overrides an earlier one on the same index.
    always_comb begin
        fwd = stored;
        for (int p = 0; p < PIPES; p++) begin
            if (wr_en[p] && (wr_addr[p] == rd_addr)) begin
                fwd = wr_data[p];
            end
        end
    end

    // Zero index masks any forwarded value.
    assign rd_data = (rd_addr == AW'(RF_ZERO_INDEX)) ? '0 : fwd;

endmodule

// File: rtl/dual_rf.sv
module dual_rf
    import dual_rf_pkg::*;
#(
    parameter int unsigned ENTRIES        = RF_ENTRIES,
    parameter int unsigned XLEN           = RF_XLEN,
    parameter int unsigned PIPES          = RF_PIPES,
    parameter int unsigned READS_PER_PIPE = RF_READS_PER_PIPE,
    localparam int unsigned AW            = $clog2(ENTRIES),
    localparam int unsigned NRD           = PIPES * READS_PER_PIPE
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NRD-1:0][AW-1:0]     rd_addr,
    output logic [NRD-1:0][XLEN-1:0]   rd_data,
    input  logic [PIPES-1:0]           wr_en,
    input  logic [PIPES-1:0][AW-1:0]   wr_addr,
    input  logic [PIPES-1:0][XLEN-1:0] wr_data
);

    logic [ENTRIES-1:0][XLEN-1:0] regs_q;

    rf_storage #(
        .ENTRIES (ENTRIES),
        .XLEN    (XLEN),
        .PIPES   (PIPES)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    // One forwarding read port per reader; ports [k*READS_PER_PIPE +: READS_PER_PIPE]
    // belong to pipe k, but every port sees every writer.
    for (genvar i = 0; i < NRD; i++) begin : g_rd
        rf_read_port #(
            .ENTRIES (ENTRIES),
            .XLEN    (XLEN),
            .PIPES   (PIPES)
        ) u_port (
            .rd_addr (rd_addr[i]),
            .regs_q  (regs_q),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_data (rd_data[i])
        );
    end

endmodule

// File: rtl/dual_rf_checker.sv
module dual_rf_checker
    import dual_rf_pkg::*;
#(
    parameter int unsigned ENTRIES        = RF_ENTRIES,
    parameter int unsigned XLEN           = RF_XLEN,
    parameter int unsigned PIPES          = RF_PIPES,
    parameter int unsigned READS_PER_PIPE = RF_READS_PER_PIPE,
    localparam int unsigned AW            = $clog2(ENTRIES),
    localparam int unsigned NRD           = PIPES * READS_PER_PIPE,
    localparam int unsigned YOUNG         = PIPES - 1
) (
    input logic                       clk,
    input logic                       rst,
    input logic [NRD-1:0][AW-1:0]     rd_addr,
    input logic [NRD-1:0][XLEN-1:0]   rd_data,
    input logic [PIPES-1:0]           wr_en,
    input logic [PIPES-1:0][AW-1:0]   wr_addr,
    input logic [PIPES-1:0][XLEN-1:0] wr_data
);

    for (genvar i = 0; i < NRD; i++) begin : g_chk
        logic hit_young;
        logic hit_old;
        logic hit_any;

        assign hit_young = wr_en[YOUNG] && (wr_addr[YOUNG] == rd_addr[i]);
        assign hit_old   = wr_en[0] && (wr_addr[0] == rd_addr[i]);
        assign hit_any   = hit_young || hit_old;

        // R2: index 0 always reads zero.
        a_r2_zero_read: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[i] == '0) |-> (rd_data[i] == '0));

        // R7 / R8: youngest writer forwards with priority.
        a_r8_young_forward: assert property (@(posedge clk) disable iff (rst)
            (hit_young && rd_addr[i] != '0) |-> (rd_data[i] == wr_data[YOUNG]));

        // R6 / R7: oldest writer forwards when the youngest does not match.
        a_r6_old_forward: assert property (@(posedge clk) disable iff (rst)
            (hit_old && !hit_young && rd_addr[i] != '0)
            |-> (rd_data[i] == wr_data[0]));

        // R4 / R9: a youngest-pipe write is visible next cycle.
        a_r9_young_commit: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(wr_en[YOUNG]) && $past(wr_addr[YOUNG]) != '0
             && rd_addr[i] == $past(wr_addr[YOUNG]) && !hit_any)
            |-> (rd_data[i] == $past(wr_data[YOUNG])));

        // R4: an oldest-pipe write without a younger collision is visible next cycle.
        a_r4_old_commit: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(wr_en[0]) && $past(wr_addr[0]) != '0
             && !($past(wr_en[YOUNG]) && $past(wr_addr[YOUNG]) == $past(wr_addr[0]))
             && rd_addr[i] == $past(wr_addr[0]) && !hit_any)
            |-> (rd_data[i] == $past(wr_data[0])));
    end

endmodule

bind dual_rf dual_rf_checker #(
    .ENTRIES        (ENTRIES),
    .XLEN           (XLEN),
    .PIPES          (PIPES),
    .READS_PER_PIPE (READS_PER_PIPE)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
);

// File: tb/dual_rf_test.sv
`timescale 1ns/1ps
module dual_rf_test;

    localparam int unsigned N   = 32;
    localparam int unsigned W   = 64;
    localparam int unsigned NP  = 2;
    localparam int unsigned NR  = 4;
    localparam int unsigned AW  = 5;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NR-1:0][AW-1:0]  rd_addr = '0;
    logic [NR-1:0][W-1:0]   rd_data;
    logic [NP-1:0]          wr_en = '0;
    logic [NP-1:0][AW-1:0]  wr_addr = '0;
    logic [NP-1:0][W-1:0]   wr_data = '0;

    int unsigned errors = 0;
    int unsigned checks = 0;
    logic [W-1:0] model [N];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dual_rf uut (
        .clk(clk), .rst(rst), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Expected read value from the requirements.
    function automatic logic [W-1:0] exp_read(input logic [AW-1:0] a);
        logic [W-1:0] v;
        if (a == '0) return '0;
        v = model[a];
        if (wr_en[0] && wr_addr[0] == a) v = wr_data[0];
        if (wr_en[1] && wr_addr[1] == a) v = wr_data[1];
        return v;
    endfunction

    // Which requirement a read exercises.
    function automatic string auto_tag(input int port, input logic [AW-1:0] a);
        bit h0, h1;
        int pipe;
        pipe = port / 2;
        h0 = wr_en[0] && wr_addr[0] == a;
        h1 = wr_en[1] && wr_addr[1] == a;
        if (a == '0) return "R2";
        if (h0 && h1) return "R8";
        if (h1) return (pipe == 1) ? "R6" : "R7";
        if (h0) return (pipe == 0) ? "R6" : "R7";
        return "R10";
    endfunction

    task automatic cycle(input bit r,
                         input bit e0, input logic [AW-1:0] a0, input logic [W-1:0] d0,
                         input bit e1, input logic [AW-1:0] a1, input logic [W-1:0] d1,
                         input logic [AW-1:0] q0, input logic [AW-1:0] q1,
                         input logic [AW-1:0] q2, input logic [AW-1:0] q3,
                         input string tag);
        @(negedge clk);
        rst = r;
        wr_en[0] = e0; wr_addr[0] = a0; wr_data[0] = d0;
        wr_en[1] = e1; wr_addr[1] = a1; wr_data[1] = d1;
        rd_addr[0] = q0; rd_addr[1] = q1; rd_addr[2] = q2; rd_addr[3] = q3;
        #1;
        if (!r) begin
            for (int i = 0; i < NR; i++) begin
                logic [W-1:0] exp;
                string t;
                exp = exp_read(rd_addr[i]);
                t = (tag == "") ? auto_tag(i, rd_addr[i]) : tag;
                checks++;
                if (rd_data[i] !== exp) begin
                    errors++;
                    $display("FAIL %s port %0d addr %0d: got %h expected %h",
                             t, i, rd_addr[i], rd_data[i], exp);
                end
            end
        end
        @(posedge clk);
        if (r) begin
            for (int k = 0; k < N; k++) model[k] = '0;
        end else begin
            if (e0 && a0 != '0) model[a0] = d0;
            if (e1 && a1 != '0) model[a1] = d1;
        end
    endtask

    task automatic idle_read(input logic [AW-1:0] q0, input logic [AW-1:0] q1,
                             input logic [AW-1:0] q2, input logic [AW-1:0] q3,
                             input string tag);
        cycle(0, 0, 0, '0, 0, 0, '0, q0, q1, q2, q3, tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("  Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < N; k++) model[k] = '0;
        // Reset with junk writes pending.
        cycle(1, 1, 5'd3, 64'hDEAD, 1, 5'd4, 64'hBEEF, 0, 0, 0, 0, "");
        cycle(1, 0, 0, '0, 0, 0, '0, 0, 0, 0, 0, "");

        // R1: all nonzero indices read zero after reset.
        for (int b = 1; b < N; b += 4)
            idle_read(AW'(b), AW'((b + 1) % N), AW'((b + 2) % N), AW'((b + 3) % N), "R1");

        // R4: commit and read back on all ports.
        cycle(0, 1, 5'd5, 64'h0123_4567_89AB_CDEF, 1, 5'd9, 64'hFEDC_BA98_7654_3210,
              1, 2, 3, 4, "");
        idle_read(5, 9, 5, 9, "R4");

        // R5: disabled writes leave state unchanged.
        cycle(0, 0, 5'd5, 64'h1111, 0, 5'd9, 64'h2222, 6, 7, 8, 10, "R5");
        idle_read(9, 5, 9, 5, "R5");

        // R2 then R3: writes to index 0 are dropped.
        cycle(0, 1, 5'd0, 64'hAAAA, 1, 5'd0, 64'h5555, 0, 0, 0, 0, "R2");
        idle_read(0, 0, 0, 0, "R3");

        // R6 / R7: single writer forwards to own and other pipe.
        cycle(0, 1, 5'd7, 64'hC0FFEE, 0, 0, '0, 7, 7, 7, 7, "");
        cycle(0, 0, 0, '0, 1, 5'd11, 64'hF00D, 11, 11, 11, 11, "");

        // R8 then R9: both writers on one index.
        cycle(0, 1, 5'd12, 64'h0A0A, 1, 5'd12, 64'h0B0B, 12, 12, 12, 12, "R8");
        idle_read(12, 12, 12, 12, "R9");

        // R10: unrelated reads while writes happen elsewhere.
        cycle(0, 1, 5'd20, 64'h77, 1, 5'd21, 64'h88, 5, 9, 7, 11, "R10");

        // Random mix, addresses biased into a small window for collisions.
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a[6];
            for (int j = 0; j < 6; j++)
                a[j] = ($urandom % 2 == 0) ? AW'($urandom % 6) : AW'($urandom % N);
            cycle(($urandom % 200) == 0,
                  $urandom % 4 != 0, a[0], {$urandom, $urandom},
                  $urandom % 4 != 0, a[1], {$urandom, $urandom},
                  a[2], a[3], a[4], a[5], "");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule